// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor that runs in several privilege modes. A 5-bit mode code comes in from the status logic, and the block steers every read and write to the copy that belongs to that mode. The fast-interrupt mode has private copies of registers 8 through 14. The other exception modes have private copies of registers 13 and 14 only. Any mode code without a bank of its own uses the shared registers. No data is copied when the mode changes. The decode just points the ports at different storage.

There are two combinational read ports and one write port. A separate direct write path lets the program-counter logic outside the block update register 15, which is never banked. Each exception mode also keeps one saved-status word. The current mode selects that word for reads, writes and restore requests. A restore returns the saved word with bit 4 forced high, or raises a bad-mode flag when the current mode has no saved-status word. A privileged output tells an external protection unit when the processor is outside user mode.

Top module: `rbf_regfile`

## Requirements
- R1: After reset, every register in every bank reads 0, and each of the five saved-status words reads 0x00000010.
- R2: A write through the general write port becomes visible on both read ports on the cycle after the rising edge that takes it. A read of the same register in the write cycle returns the old value.
- R3: With mode 0x11, registers 8 to 14 map to seven private fast-interrupt registers. Registers 0 to 7 and 15 map to the shared set.
- R4: Modes 0x12, 0x13, 0x17 and 0x1B each map registers 13 and 14 to two private registers of their own. All other registers map to the shared set.
- R5: Any other mode code maps all sixteen registers to the shared set. This includes 0x10, 0x1F, 0x14 and 0x18.
- R6: The saved-status port is addressed by the mode code, as follows:
  - 0x11 selects the fast-interrupt word.
  - 0x12 selects the interrupt word.
  - 0x13 selects the supervisor word.
  - 0x14 to 0x17 select the abort word.
  - 0x18 to 0x1B select the undefined word.
  
  In all other modes a saved-status write is ignored and a saved-status read returns 0.
- R7: When a restore is requested in a mode that has a saved-status word, the restore-valid output is high in the same cycle. The restore value is that word with bit 4 set to 1.
- R8: When a restore is requested in a mode with no saved-status word, restore-valid is low and the bad-mode flag is high. Bad-mode is low whenever no restore is requested.
- R9: The privileged output is low exactly when the mode code is 0x10.
- R10: The direct register-15 write path updates register 15 in every mode. When it fires in the same cycle as a general write to register 15, the direct path wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write register number |
| wr_data | input | 32 | General write data |
| pc_wr_en | input | 1 | Direct register-15 write enable |
| pc_wr_data | input | 32 | Direct register-15 write data |
| sst_wr_en | input | 1 | Saved-status write enable |
| sst_wr_data | input | 32 | Saved-status write data |
| sst_rd_data | output | 32 | Saved-status word of the current mode |
| restore_req | input | 1 | Request to restore saved status |
| restore_val | output | 32 | Restored status value, bit 4 forced |
| restore_ok | output | 1 | Restore accepted in this mode |
| bad_mode | output | 1 | Restore requested in a mode with no saved word |
| privileged_o | output | 1 | High outside user mode |

## Verification
The read ports, the saved-status read, the restore outputs and the privileged flag are all combinational. They are due in the same cycle that their inputs are presented. The bench therefore drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. Every write, whether general, direct register-15 or saved-status, appears only after one rising edge. Write results are checked on a later low phase, and one test reads a register during the cycle that writes it to confirm that the old value is still seen there. The sweeps cover all 32 mode codes against all 16 register numbers, on both read ports with different addresses.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    localparam int MODE_W       = 5;
    localparam int NREG         = 16;
    localparam int ADDR_W       = $clog2(NREG);
    localparam int FIQ_FIRST    = 8;
    localparam int N_FIQ        = 7;
    localparam int SHADOW_FIRST = 13;
    localparam int N_SHADOW     = 2;
    localparam int N_EXC        = 4;
    localparam int N_SST        = 5;
    localparam int SST_IW       = $clog2(N_SST);
    localparam int EXC_IW       = $clog2(N_EXC);
    localparam int FIQ_IW       = $clog2(N_FIQ);
    localparam int SHD_IW       = $clog2(N_SHADOW);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

    typedef enum logic [2:0] {
        BK_SHARED, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND
    } bank_e;

    typedef enum logic [1:0] {
        LOC_SHARED, LOC_FIQ, LOC_SHADOW
    } loc_e;

    typedef struct packed {
        loc_e              loc;
        logic [ADDR_W-1:0] gidx;
        logic [FIQ_IW-1:0] fidx;
        logic [EXC_IW-1:0] eidx;
        logic [SHD_IW-1:0] sidx;
    } loc_t;

    function automatic loc_t locate(input bank_e bank, input logic [ADDR_W-1:0] addr);
        loc_t r;
        r.loc  = LOC_SHARED;
        r.gidx = addr;
        r.fidx = FIQ_IW'(addr - ADDR_W'(FIQ_FIRST));
        r.sidx = SHD_IW'(addr - ADDR_W'(SHADOW_FIRST));
        case (bank)
            BK_IRQ:  r.eidx = EXC_IW'(0);
            BK_SVC:  r.eidx = EXC_IW'(1);
            BK_ABT:  r.eidx = EXC_IW'(2);
            default: r.eidx = EXC_IW'(3);
        endcase
        if (bank == BK_FIQ) begin
            if (addr >= ADDR_W'(FIQ_FIRST) && addr < ADDR_W'(FIQ_FIRST + N_FIQ))
                r.loc = LOC_FIQ;
        end else if (bank != BK_SHARED) begin
            if (addr >= ADDR_W'(SHADOW_FIRST) && addr < ADDR_W'(SHADOW_FIRST + N_SHADOW))
                r.loc = LOC_SHADOW;
        end
        return r;
    endfunction

endpackage

// File: rtl/rbf_mode_decode.sv
module rbf_mode_decode
    import rbf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              sst_hit,
    output logic [SST_IW-1:0] sst_idx,
    output logic              privileged
);
    always_comb begin
        case (mode)
            MODE_FIQ: bank = BK_FIQ;
            MODE_IRQ: bank = BK_IRQ;
            MODE_SVC: bank = BK_SVC;
            MODE_ABT: bank = BK_ABT;
            MODE_UND: bank = BK_UND;
            default:  bank = BK_SHARED;
        endcase
    end

    always_comb begin
        sst_hit = 1'b1;
        sst_idx = '0;
        case (mode)
            5'h11:                      sst_idx = SST_IW'(0);
            5'h12:                      sst_idx = SST_IW'(1);
            5'h13:                      sst_idx = SST_IW'(2);
            5'h14, 5'h15, 5'h16, 5'h17: sst_idx = SST_IW'(3);
            5'h18, 5'h19, 5'h1A, 5'h1B: sst_idx = SST_IW'(4);
            default:                    sst_hit = 1'b0;
        endcase
    end

    assign privileged = (mode != MODE_USR);
endmodule

// File: rtl/rbf_read_port.sv
module rbf_read_port
    import rbf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  bank_e                                    bank,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [NREG-1:0][XLEN-1:0]                gpr,
    input  logic [N_FIQ-1:0][XLEN-1:0]               fiq,
    input  logic [N_EXC-1:0][N_SHADOW-1:0][XLEN-1:0] shd,
    output logic [XLEN-1:0]                          data
);
    loc_t where;

    always_comb begin
        where = locate(bank, addr);
        case (where.loc)
            LOC_FIQ:    data = fiq[where.fidx];
            LOC_SHADOW: data = shd[where.eidx][where.sidx];
            default:    data = gpr[where.gidx];
        endcase
    end
endmodule

// File: rtl/rbf_regfile.sv
module rbf_regfile
    import rbf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_addr,
    output logic [XLEN-1:0]   rd_a_data,
    input  logic [3:0]        rd_b_addr,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              pc_wr_en,
    input  logic [XLEN-1:0]   pc_wr_data,
    input  logic              sst_wr_en,
    input  logic [XLEN-1:0]   sst_wr_data,
    output logic [XLEN-1:0]   sst_rd_data,
    input  logic              restore_req,
    output logic [XLEN-1:0]   restore_val,
    output logic              restore_ok,
    output logic              bad_mode,
    output logic              privileged_o
);
    localparam int                NRP       = 2;
    localparam int                PC_IDX    = NREG - 1;
    localparam int                FORCE_BIT = 4;
    localparam logic [XLEN-1:0]   SST_RST   = XLEN'(1) << FORCE_BIT;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0]                gpr;
        logic [N_FIQ-1:0][XLEN-1:0]               fiq;
        logic [N_EXC-1:0][N_SHADOW-1:0][XLEN-1:0] shd;
        logic [N_SST-1:0][XLEN-1:0]               sst;
    } state_t;

    state_t            st_d, st_q;
    bank_e             bank;
    logic              sst_hit;
    logic [SST_IW-1:0] sst_idx;
    loc_t              wloc;

    rbf_mode_decode u_dec (
        .mode       (mode_i),
        .bank       (bank),
        .sst_hit    (sst_hit),
        .sst_idx    (sst_idx),
        .privileged (privileged_o)
    );

    logic [ADDR_W-1:0] rp_addr [NRP];
    logic [XLEN-1:0]   rp_data [NRP];

    assign rp_addr[0] = rd_a_addr;
    assign rp_addr[1] = rd_b_addr;
    assign rd_a_data  = rp_data[0];
    assign rd_b_data  = rp_data[1];

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        rbf_read_port #(.XLEN(XLEN)) u_rp (
            .bank (bank),
            .addr (rp_addr[p]),
            .gpr  (st_q.gpr),
            .fiq  (st_q.fiq),
            .shd  (st_q.shd),
            .data (rp_data[p])
        );
    end

    always_comb begin
        st_d = st_q;
        wloc = locate(bank, wr_addr);
        if (wr_en) begin
            case (wloc.loc)
                LOC_FIQ:    st_d.fiq[wloc.fidx]            = wr_data;
                LOC_SHADOW: st_d.shd[wloc.eidx][wloc.sidx] = wr_data;
                default:    st_d.gpr[wloc.gidx]            = wr_data;
            endcase
        end
        if (pc_wr_en)
            st_d.gpr[PC_IDX] = pc_wr_data;
        if (sst_wr_en && sst_hit)
            st_d.sst[sst_idx] = sst_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gpr <= '0;
            st_q.fiq <= '0;
            st_q.shd <= '0;
            for (int i = 0; i < N_SST; i++)
                st_q.sst[i] <= SST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sst_rd_data = sst_hit ? st_q.sst[sst_idx] : '0;
    assign restore_val = sst_hit ? (st_q.sst[sst_idx] | SST_RST) : '0;
    assign restore_ok  = restore_req && sst_hit;
    assign bad_mode    = restore_req && !sst_hit;
endmodule

// File: rtl/rbf_regfile_chk.sv
module rbf_regfile_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      mode_i,
    input logic [3:0]      rd_a_addr,
    input logic [XLEN-1:0] rd_a_data,
    input logic [3:0]      rd_b_addr,
    input logic [XLEN-1:0] rd_b_data,
    input logic            wr_en,
    input logic [3:0]      wr_addr,
    input logic [XLEN-1:0] wr_data,
    input logic            pc_wr_en,
    input logic [XLEN-1:0] pc_wr_data,
    input logic            sst_wr_en,
    input logic [XLEN-1:0] sst_wr_data,
    input logic [XLEN-1:0] sst_rd_data,
    input logic            restore_req,
    input logic [XLEN-1:0] restore_val,
    input logic            restore_ok,
    input logic            bad_mode,
    input logic            privileged_o
);
    a_r2_write_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pc_wr_en && wr_addr == rd_a_addr)
        |=> (!($stable(mode_i) && $stable(rd_a_addr)) || rd_a_data == $past(wr_data)));

    a_r7_restore_bit4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_ok |-> restore_val[4]);

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> $countones({restore_ok, bad_mode}) == 1);

    a_r8_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_req |-> !(restore_ok || bad_mode));

    a_r9_user_unprivileged: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 5'h10) |-> !privileged_o);

    a_r10_pc_path: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |=> (rd_b_addr != 4'd15 || rd_b_data == $past(pc_wr_data)));

    a_r6_sst_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sst_wr_en && restore_ok) |=> (!$stable(mode_i) || sst_rd_data == $past(sst_wr_data)));
endmodule

bind rbf_regfile rbf_regfile_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rbf_regfile_tb.sv
module rbf_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'h10;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, sst_rd_data, restore_val;
    logic        wr_en = 1'b0, pc_wr_en = 1'b0, sst_wr_en = 1'b0, restore_req = 1'b0;
    logic [31:0] wr_data = '0, pc_wr_data = '0, sst_wr_data = '0;
    logic        restore_ok, bad_mode, privileged_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [31];
    logic [31:0] msst  [5];

    always #10 clk = ~clk;

    rbf_regfile #(.XLEN(32)) u_dut (.*);

    function automatic int flat_idx(input logic [4:0] m, input int a);
        int ex;
        if (m == 5'h11 && a >= 8 && a <= 14) return 16 + a - 8;
        case (m)
            5'h12:   ex = 0;
            5'h13:   ex = 1;
            5'h17:   ex = 2;
            5'h1B:   ex = 3;
            default: ex = -1;
        endcase
        if (ex >= 0 && (a == 13 || a == 14)) return 23 + ex * 2 + (a - 13);
        return a;
    endfunction

    function automatic int sst_slot(input logic [4:0] m);
        if (m == 5'h11) return 0;
        if (m == 5'h12) return 1;
        if (m == 5'h13) return 2;
        if (m >= 5'h14 && m <= 5'h17) return 3;
        if (m >= 5'h18 && m <= 5'h1B) return 4;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic gwrite(input logic [4:0] m, input int a, input logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[flat_idx(m, a)] = d;
    endtask

    task automatic sweep_regs(input string req);
        for (int m = 0; m < 32; m++) begin
            for (int a = 0; a < 16; a++) begin
                @(negedge clk);
                mode_i = 5'(m); rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a);
                #1;
                chk(req, rd_a_data, model[flat_idx(5'(m), a)]);
                chk(req, rd_b_data, model[flat_idx(5'(m), 15 - a)]);
            end
        end
    endtask

    task automatic sweep_sst(input string req);
        for (int m = 0; m < 32; m++) begin
            int s;
            s = sst_slot(5'(m));
            @(negedge clk);
            mode_i = 5'(m); restore_req = 1'b1;
            #1;
            chk({req, " R6 read"}, sst_rd_data, (s >= 0) ? msst[s] : 32'h0);
            chk("R7 R8 restore_ok", {31'b0, restore_ok}, {31'b0, s >= 0});
            chk("R8 bad_mode", {31'b0, bad_mode}, {31'b0, s < 0});
            if (s >= 0) chk("R7 restore_val", restore_val, msst[s] | 32'h10);
            chk("R9 privileged", {31'b0, privileged_o}, {31'b0, m != 16});
            restore_req = 1'b0;
            #1;
            chk("R8 idle flag", {30'b0, restore_ok, bad_mode}, 32'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < 31; i++) model[i] = '0;
        for (int i = 0; i < 5; i++) msst[i] = 32'h10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across every mode
        sweep_regs("R1 reset regs");
        sweep_sst("R1 reset sst");

        // R3 R4 R5: fill each bank view with distinct data
        begin
            logic [4:0] ml [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h14};
            for (int k = 0; k < 8; k++)
                for (int a = 0; a < 15; a++)
                    gwrite(ml[k], a, {8'hC0 ^ {3'b0, ml[k]}, 8'(a), 16'h5A00 + 16'(k)});
        end
        sweep_regs("R3 R4 R5 banked view");

        // R2: same-cycle read sees old value, next cycle sees new
        @(negedge clk);
        mode_i = 5'h12; rd_a_addr = 4'd13; rd_b_addr = 4'd13;
        wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hDEAD_0013;
        #1;
        chk("R2 old value in write cycle", rd_a_data, model[flat_idx(5'h12, 13)]);
        @(negedge clk);
        wr_en = 1'b0;
        model[flat_idx(5'h12, 13)] = 32'hDEAD_0013;
        #1;
        chk("R2 new value port A", rd_a_data, 32'hDEAD_0013);
        chk("R2 new value port B", rd_b_data, 32'hDEAD_0013);
        mode_i = 5'h13;
        #1;
        chk("R4 other bank untouched", rd_a_data, model[flat_idx(5'h13, 13)]);

        // R10: direct path alone, then against a general write
        @(negedge clk);
        mode_i = 5'h11; pc_wr_en = 1'b1; pc_wr_data = 32'h0000_1234;
        @(negedge clk);
        pc_wr_en = 1'b0; model[15] = 32'h0000_1234;
        mode_i = 5'h10; rd_a_addr = 4'd15;
        #1;
        chk("R10 direct write shared", rd_a_data, 32'h0000_1234);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd15; wr_data = 32'h1111_1111;
        pc_wr_en = 1'b1; pc_wr_data = 32'h2222_2222;
        @(negedge clk);
        wr_en = 1'b0; pc_wr_en = 1'b0; model[15] = 32'h2222_2222;
        #1;
        chk("R10 priority", rd_a_data, 32'h2222_2222);

        // R6: saved-status writes in every mode code
        for (int m = 0; m < 32; m++) begin
            int s;
            logic [31:0] v;
            s = sst_slot(5'(m));
            v = 32'h3C00_0000 | (32'(m) << 8) | 32'h0000_0025;
            @(negedge clk);
            mode_i = 5'(m); sst_wr_en = 1'b1; sst_wr_data = v;
            @(negedge clk);
            sst_wr_en = 1'b0;
            if (s >= 0) msst[s] = v;
        end
        sweep_sst("R6 after writes");
        sweep_regs("R6 regs unaffected");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule